// File: doc/BRIEF.md
# Processor Idle-State Sequencer with Throttling

This block decides which idle state, C0 to C4, the processor is in, and drives the stop-clock request that moves it between them. Software asks for a deeper state by reading a level register. That read shows up here as a one-cycle request for C2, C3 or C4. The block then holds the stop-clock request until a break event brings the processor back to C0. A halted processor sits in C1 and returns to C0 when the halt ends.

Bus-master traffic gets special treatment. A request for C3 or C4 made while a bus master is active parks in C2 and reports a deferral. It moves on to the requested state once the traffic stops, or it goes to C0 on a break. Once the processor is in C3 or C4, bus-master traffic can do one of three things, chosen by two configuration inputs: ignore it, treat it as a break, or fall back to C2. Software throttling is the lowest priority. While it is enabled, a phase counter that wraps every `PERIOD` clocks asserts stop-clock for a programmable number of eighths of each period.

The counter is held at zero in four cases: during a level-requested idle, during sleep entry, while throttling is off, and during reset. As a result, throttling resumes after a break with its first assertion delayed by part of one period.

Top module: `idle_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to C0 with `stop_clk` low and `defer_pend` low.
- R2: `cstate` is encoded as C0=0, C1=1, C2=2, C3=3, C4=4. When no bus master is active, a level request moves C0 or C1 to the requested state at the next edge. If several requests arrive at once, the deepest wins. `stop_clk` stays high in that state, and further requests are ignored, until a break.
- R3: If any bit of `brk_evt` is high while the block is in a level-requested C2, C3 or C4, or in a deferred C2, the next state is C0.
- R4: Bus-master activity is never a break in C2. In C3 or C4 it is a break only while `bm_brk_en` is 1 and `bm_to_c2` is 0.
- R5: While `bm_to_c2` is 1, bus-master activity in C3 or C4 with no break moves the block to a level-held C2, with `stop_clk` high and `defer_pend` low.
- R6: A C3 or C4 request made while `bm_active` is 1 enters C2 with `defer_pend` high. The block stays there while bus-master activity continues, because that activity is not a break. When `bm_active` falls, the block moves to the requested state at the next edge and `defer_pend` goes low. A break moves it to C0.
- R7: With no request pending, C0 goes to C1 while `cpu_halt` is high, and C1 returns to C0 when it is low.
- R8: Throttling runs when `thr_en` or `thr_force` is 1, `sleep_req` is 0, and the block is not in a level-held or deferred state. While it runs, a phase counter counts 0 to `PERIOD`-1 and wraps. `stop_clk` is high while phase >= `PERIOD` - `thr_duty`*`PERIOD`/8, so a duty of 0 never asserts it. When throttling does not run, the phase is held at 0.
- R9: After a break exit to C0 with throttling enabled, `stop_clk` first rises exactly `PERIOD` - `thr_duty`*`PERIOD`/8 clocks after the exit edge.
- R10: In C1, a throttle assertion of `stop_clk` moves the block to C2 at the next edge. When the assertion ends, the block returns to C1 at the following edge.
- R11: While `sleep_req` is 1, level requests are ignored and throttling never asserts `stop_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lvl_c2_rd | input | 1 | One-cycle request for C2 |
| lvl_c3_rd | input | 1 | One-cycle request for C3 |
| lvl_c4_rd | input | 1 | One-cycle request for C4 |
| brk_evt | input | N_BRK | Enabled break events, any bit breaks |
| bm_active | input | 1 | Bus-master activity |
| bm_brk_en | input | 1 | Bus-master activity breaks C3/C4 |
| bm_to_c2 | input | 1 | Bus-master activity returns C3/C4 to C2 only |
| cpu_halt | input | 1 | Processor halted (C1) |
| thr_en | input | 1 | Throttle enable |
| thr_force | input | 1 | Forced throttle |
| thr_duty | input | DUTY_W | Stop-clock share of period in eighths |
| sleep_req | input | 1 | Sleep entry in progress |
| stop_clk | output | 1 | Stop-clock request |
| cstate | output | 3 | Current idle state |
| defer_pend | output | 1 | C3/C4 entry deferred at C2 |

## Verification
The vector walk covers several bus-master cases, each with a characteristic failure:
- Traffic in plain C2 is a break for the wrong reason; a design that gets this wrong falls to C0.
- A deferred C2 either releases to C2 or C0 instead of the target, or it treats continuing traffic as a break.
- The `bm_to_c2` override does not take priority over the reload bit.

Two directed tests measure throttle timing to the exact clock. One checks the C1 to C2 hand-off and its return after the period wraps. The other checks the first assertion after a break. A counter that is not cleared during idle, or an off-by-one threshold, shifts these edges by a cycle. Sleep entry and a zero duty are checked over long windows to confirm that `stop_clk` never rises and that a level read is ignored.

// File: rtl/idle_seq_pkg.sv
package idle_seq_pkg;
   typedef enum logic [2:0] {
      CS_C0 = 3'd0,
      CS_C1 = 3'd1,
      CS_C2 = 3'd2,
      CS_C3 = 3'd3,
      CS_C4 = 3'd4
   } cstate_e;

   // why the block is sitting in C2..C4
   typedef enum logic [1:0] {
      HOLD_LVL = 2'd0,
      HOLD_DEF = 2'd1,
      HOLD_THR = 2'd2
   } hold_e;
endpackage

// File: rtl/idle_thr_timer.sv
module idle_thr_timer #(
   parameter int PERIOD = 1024,
   parameter int DUTY_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [DUTY_W-1:0] duty,
   output logic              stp
);
   localparam int CW     = $clog2(PERIOD);
   localparam int SLICES = 1 << DUTY_W;
   localparam int SLICE  = PERIOD / SLICES;
   localparam logic [CW:0] PER_V   = (CW+1)'(PERIOD);
   localparam logic [CW:0] SLICE_V = (CW+1)'(SLICE);

   generate
      if (PERIOD % SLICES != 0) begin : g_bad_period
         $error("PERIOD must be a multiple of 2**DUTY_W");
      end
      if (PERIOD < 2) begin : g_bad_small
         $error("PERIOD must be at least 2");
      end
   endgenerate

   logic [CW-1:0] phase;
   logic [CW:0]   thresh;

   assign thresh = PER_V - ((CW+1)'(duty) * SLICE_V);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         phase <= '0;
      end else if ({1'b0, phase} == PER_V - 1'b1) begin
         phase <= '0;
      end else begin
         phase <= phase + 1'b1;
      end
   end

   assign stp = run && ({1'b0, phase} >= thresh);

   // R8
   phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, phase} < PER_V);
endmodule

// File: rtl/idle_state_fsm.sv
module idle_state_fsm
   import idle_seq_pkg::*;
#(
   parameter int N_BRK = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl_c2,
   input  logic             lvl_c3,
   input  logic             lvl_c4,
   input  logic [N_BRK-1:0] brk_evt,
   input  logic             bm_active,
   input  logic             bm_brk_en,
   input  logic             bm_to_c2,
   input  logic             cpu_halt,
   input  logic             sleep_req,
   input  logic             thr_stp,
   output cstate_e          cstate,
   output logic             hold_stp,
   output logic             defer_pend
);
   generate
      if (N_BRK < 1) begin : g_bad_brk
         $error("N_BRK must be at least 1");
      end
   endgenerate

   cstate_e state_q, state_d, tgt_q, tgt_d, lvl_tgt, ent_state;
   hold_e   hold_q, hold_d, ent_hold;
   logic    lvl_any, deep, hard_brk, bm_brk;

   assign lvl_any  = (lvl_c2 || lvl_c3 || lvl_c4) && !sleep_req;
   assign lvl_tgt  = lvl_c4 ? CS_C4 : (lvl_c3 ? CS_C3 : CS_C2);
   assign deep     = (state_q == CS_C3) || (state_q == CS_C4);
   assign hard_brk = |brk_evt;
   assign bm_brk   = bm_active && bm_brk_en && !bm_to_c2 && deep;

   always_comb begin
      if (lvl_tgt != CS_C2 && bm_active) begin
         ent_state = CS_C2;
         ent_hold  = HOLD_DEF;
      end else begin
         ent_state = lvl_tgt;
         ent_hold  = HOLD_LVL;
      end
   end

   always_comb begin
      state_d = state_q;
      hold_d  = hold_q;
      tgt_d   = tgt_q;
      case (state_q)
         CS_C0: begin
            if (lvl_any) begin
               state_d = ent_state; hold_d = ent_hold; tgt_d = lvl_tgt;
            end else if (cpu_halt) begin
               state_d = CS_C1;
            end
         end
         CS_C1: begin
            if (lvl_any) begin
               state_d = ent_state; hold_d = ent_hold; tgt_d = lvl_tgt;
            end else if (thr_stp && !sleep_req) begin
               state_d = CS_C2; hold_d = HOLD_THR;
            end else if (!cpu_halt) begin
               state_d = CS_C0;
            end
         end
         CS_C2: begin
            case (hold_q)
               HOLD_LVL: if (hard_brk) state_d = CS_C0;
               HOLD_DEF: begin
                  if (hard_brk) begin
                     state_d = CS_C0;
                  end else if (!bm_active) begin
                     state_d = tgt_q; hold_d = HOLD_LVL;
                  end
               end
               default: begin
                  if (lvl_any) begin
                     state_d = ent_state; hold_d = ent_hold; tgt_d = lvl_tgt;
                  end else if (!thr_stp) begin
                     state_d = CS_C1;
                  end
               end
            endcase
         end
         CS_C3, CS_C4: begin
            if (hard_brk || bm_brk) begin
               state_d = CS_C0;
            end else if (bm_active && bm_to_c2) begin
               state_d = CS_C2; hold_d = HOLD_LVL;
            end
         end
         default: state_d = CS_C0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= CS_C0;
         hold_q  <= HOLD_LVL;
         tgt_q   <= CS_C3;
      end else begin
         state_q <= state_d;
         hold_q  <= hold_d;
         tgt_q   <= tgt_d;
      end
   end

   assign cstate     = state_q;
   assign hold_stp   = (state_q >= CS_C2) && (hold_q != HOLD_THR);
   assign defer_pend = (state_q == CS_C2) && (hold_q == HOLD_DEF);

   // R3
   brk_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hard_brk && hold_stp) |=> (cstate == CS_C0));
   // R6
   defer_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (defer_pend && !bm_active && !hard_brk) |=>
         ((cstate == CS_C3 || cstate == CS_C4) && !defer_pend));
   // R5
   bm_c2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (deep && bm_active && bm_to_c2 && !hard_brk) |=>
         (cstate == CS_C2 && !defer_pend));
   // R11
   sleep_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_req && state_q <= CS_C1) |=> (cstate <= CS_C1));
endmodule

// File: rtl/idle_seq.sv
module idle_seq
   import idle_seq_pkg::*;
#(
   parameter int N_BRK  = 4,
   parameter int PERIOD = 1024,
   parameter int DUTY_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lvl_c2_rd,
   input  logic              lvl_c3_rd,
   input  logic              lvl_c4_rd,
   input  logic [N_BRK-1:0]  brk_evt,
   input  logic              bm_active,
   input  logic              bm_brk_en,
   input  logic              bm_to_c2,
   input  logic              cpu_halt,
   input  logic              thr_en,
   input  logic              thr_force,
   input  logic [DUTY_W-1:0] thr_duty,
   input  logic              sleep_req,
   output logic              stop_clk,
   output logic [2:0]        cstate,
   output logic              defer_pend
);
   cstate_e st;
   logic    hold_stp, thr_run, thr_stp;

   assign thr_run = (thr_en || thr_force) && !sleep_req && !hold_stp;

   idle_thr_timer #(.PERIOD(PERIOD), .DUTY_W(DUTY_W)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (thr_run),
      .duty (thr_duty),
      .stp  (thr_stp)
   );

   idle_state_fsm #(.N_BRK(N_BRK)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl_c2    (lvl_c2_rd),
      .lvl_c3    (lvl_c3_rd),
      .lvl_c4    (lvl_c4_rd),
      .brk_evt   (brk_evt),
      .bm_active (bm_active),
      .bm_brk_en (bm_brk_en),
      .bm_to_c2  (bm_to_c2),
      .cpu_halt  (cpu_halt),
      .sleep_req (sleep_req),
      .thr_stp   (thr_stp),
      .cstate    (st),
      .hold_stp  (hold_stp),
      .defer_pend(defer_pend)
   );

   assign stop_clk = hold_stp || thr_stp;
   assign cstate   = st;

   // R2
   deep_stp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cstate == 3'd3 || cstate == 3'd4) |-> stop_clk);
   // R11
   sleep_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_req && cstate <= 3'd1) |-> !stop_clk);
endmodule

// File: tb/idle_seq_bench.sv
module idle_seq_bench;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       c2, c3, c4;
   logic [3:0] brk;
   logic       bm, bm_rel, bm_c2, halt, t_en, t_frc, slp;
   logic [2:0] duty;
   logic       stp;
   logic [2:0] cst;
   logic       dfr;
   int         checks = 0;
   int         errors = 0;
   bit         done   = 0;

   always #10 clk = ~clk;

   idle_seq u_idle_seq (
      .clk(clk), .rst_n(rst_n), .lvl_c2_rd(c2), .lvl_c3_rd(c3), .lvl_c4_rd(c4),
      .brk_evt(brk), .bm_active(bm), .bm_brk_en(bm_rel), .bm_to_c2(bm_c2),
      .cpu_halt(halt), .thr_en(t_en), .thr_force(t_frc), .thr_duty(duty),
      .sleep_req(slp), .stop_clk(stp), .cstate(cst), .defer_pend(dfr)
   );

   // {c4,c3,c2, brk, bm, bm_rel, bm_c2, halt, exp_state[2:0], exp_defer, exp_stp}
   localparam int NV = 17;
   localparam logic [12:0] VEC [NV] = '{
      13'b000_0000_1_001_0_0, // R7 halt -> C1
      13'b001_0000_1_010_0_1, // R2 C2 read from C1
      13'b000_0000_1_010_0_1, // R2 held
      13'b000_0100_1_010_0_1, // R4 bm no break in C2
      13'b000_1000_0_000_0_0, // R3 break
      13'b010_0100_0_010_1_1, // R6 deferred C3
      13'b000_0110_0_010_1_1, // R6 bm not a break while deferred
      13'b000_0000_0_011_0_1, // R6 release to C3
      13'b000_0100_0_011_0_1, // R4 bm without reload ignored
      13'b000_0110_0_000_0_0, // R4 bm with reload breaks
      13'b100_0000_0_100_0_1, // R2 C4
      13'b000_0111_0_010_0_1, // R5 bm to C2 overrides reload
      13'b000_1000_0_000_0_0, // R3
      13'b100_0100_0_010_1_1, // R6 deferred C4
      13'b000_1100_0_000_0_0, // R6 break from deferred
      13'b110_0000_0_100_0_1, // R2 deepest wins
      13'b000_1000_0_000_0_0  // R3
   };
   localparam int TAG [NV] = '{7,2,2,4,3,6,6,6,4,4,2,5,3,6,6,2,3};

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      c2 = 0; c3 = 0; c4 = 0; brk = '0; bm = 0; bm_rel = 0; bm_c2 = 0;
      halt = 0; t_en = 0; t_frc = 0; duty = '0; slp = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      idle_inputs();
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      rst_n = 0;
      idle_inputs();
      t_en = 1; duty = 3'd7;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      // R1 reset state, throttle requested but held off
      chk("R1 state", cst, 0);
      chk("R1 stop_clk", stp, 0);
      chk("R1 defer", dfr, 0);
      do_reset();

      for (int i = 0; i < NV; i++) begin
         {c4, c3, c2, brk[0], bm, bm_rel, bm_c2, halt} = VEC[i][12:5];
         @(posedge clk);
         @(negedge clk);
         chk($sformatf("R%0d row %0d state", TAG[i], i), cst, int'(VEC[i][4:2]));
         chk($sformatf("R%0d row %0d defer", TAG[i], i), dfr, int'(VEC[i][1]));
         chk($sformatf("R%0d row %0d stop", TAG[i], i), stp, int'(VEC[i][0]));
         c2 = 0; c3 = 0; c4 = 0; brk = '0;
      end

      // R11 sleep blocks level reads and throttling
      do_reset();
      slp = 1; t_frc = 1; duty = 3'd7; c3 = 1;
      @(posedge clk); @(negedge clk);
      c3 = 0;
      chk("R11 read ignored", cst, 0);
      begin
         int hi = 0;
         for (int k = 0; k < 1100; k++) begin
            @(negedge clk);
            if (stp) hi++;
         end
         chk("R11 no throttle", hi, 0);
      end

      // R8 zero duty never asserts
      do_reset();
      t_en = 1; duty = 3'd0;
      begin
         int hi = 0;
         for (int k = 0; k < 1100; k++) begin
            @(negedge clk);
            if (stp) hi++;
         end
         chk("R8 zero duty", hi, 0);
      end

      // R10 / R8 throttle in C1, duty 4 -> threshold 512
      do_reset();
      halt = 1; t_en = 1; duty = 3'd4;
      repeat (511) @(posedge clk);
      @(negedge clk);
      chk("R8 before threshold", stp, 0);
      @(posedge clk); @(negedge clk);
      chk("R8 at threshold", stp, 1);
      chk("R10 still C1", cst, 1);
      @(posedge clk); @(negedge clk);
      chk("R10 enters C2", cst, 2);
      repeat (511) @(posedge clk);
      @(negedge clk);
      chk("R8 wrap clears", stp, 0);
      chk("R10 C2 until edge", cst, 2);
      @(posedge clk); @(negedge clk);
      chk("R10 back to C1", cst, 1);

      // R9 throttle resumes after break, duty 2 -> threshold 768
      do_reset();
      t_en = 1; duty = 3'd2; c2 = 1;
      @(posedge clk); @(negedge clk);
      c2 = 0;
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk("R2 held over throttle", stp, 1);
      brk = 4'b0100;
      @(posedge clk); @(negedge clk);
      brk = '0;
      chk("R3 break exit", cst, 0);
      repeat (767) @(posedge clk);
      @(negedge clk);
      chk("R9 before first", stp, 0);
      @(posedge clk); @(negedge clk);
      chk("R9 first assertion", stp, 1);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R1 actual=timeout expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule